// File: doc/BRIEF.md
# Two-Part Long Branch-With-Link Combiner

This block resolves the long branch-with-link sequence of a 16-bit compact instruction set. That sequence is split into two halfword instructions. The head half carries the upper part of the offset and leaves a partial address in the link register. The tail half carries the lower part of the offset. It combines that offset with the partial address, writes the return address back into the link register and requests a jump. The two halves share no state inside this block. Everything the tail needs arrives through the link register value supplied with it.

Each halfword enters as one beat on a valid/ready input stream. The beat carries a head/tail flag, the 11-bit offset field, the tail's selector bit (instruction bit 12), the current PC and the current link register. A plain control pin, `legacy_core`, tells the block that it sits in the older core variant. For each accepted beat the block produces one result beat on a valid/ready output stream. The result carries the new link register value, a branch flag, the jump target, the instruction-set state to run in after the jump, and the cycle cost. The output stage is a single register. An input beat is accepted when that register is empty or is being drained in the same cycle. While a result waits for the consumer, its contents are held unchanged and no new input is taken. Results leave in the order their beats were accepted, one cycle after acceptance at the earliest.

Top module: `lbl_combiner`

## Requirements
- R1: For a head beat (`in_tail`=0), `out_lr` equals `in_pc` plus the 11-bit offset shifted left by 12 and sign-extended from its bit 22, modulo 2^32.
- R2: A head beat yields `out_branch`=0, `out_target`=0, `out_compact`=1, `out_seq_cyc`=1 and `out_nseq_cyc`=0.
- R3: For a tail beat, the raw target is `in_lr` plus the offset shifted left by 1 (zero-extended), modulo 2^32. `out_target` is this raw value with only its low bits altered as in R5 and R6.
- R4: For a tail beat, `out_lr` equals (`in_pc` minus 2) with bit 0 forced to 1.
- R5: On a tail beat, bit 0 of the raw target is set when `legacy_core`=1 or `in_sel`=1. Whenever the resulting bit 0 is 1, the branch stays in compact state: `out_compact`=1 and `out_target` is the raw value with bit 0 cleared. This includes the case where the raw sum is already odd.
- R6: When the tail's bit 0 ends up 0, the branch switches to the 32-bit state: `out_compact`=0 and `out_target` is the raw value with bits 1 and 0 cleared.
- R7: A tail beat yields `out_branch`=1, `out_seq_cyc`=2 and `out_nseq_cyc`=1.
- R8: `in_ready` is high exactly when `out_valid`=0 or `out_ready`=1. While `out_valid`=1 and `out_ready`=0, every output holds its value into the next cycle. Results appear in acceptance order, one per accepted beat.
- R9: During and right after reset (`rst_n`=0), `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_core | input | 1 | 1 selects the older core variant (tail always stays compact) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_tail | input | 1 | 0 = head half, 1 = tail half |
| in_offset | input | 11 | Offset field of the halfword |
| in_sel | input | 1 | Selector bit (instruction bit 12) of the tail half |
| in_pc | input | 32 | PC value seen by the halfword |
| in_lr | input | 32 | Current link register value |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result when high together with out_valid |
| out_lr | output | 32 | New link register value |
| out_branch | output | 1 | 1 on tail results: jump request |
| out_target | output | 32 | Jump target (0 on head results) |
| out_compact | output | 1 | 1 = run compact code after the jump, 0 = 32-bit code |
| out_seq_cyc | output | 2 | Sequential cycles charged |
| out_nseq_cyc | output | 2 | Non-sequential cycles charged |

## Verification
The assertions assume that the consumer drives `out_ready` as a plain level. They also assume that `legacy_core`, `in_sel` and the other fields matter only in the cycle their beat is accepted, so those fields may change freely between beats. The stimulus randomizes every input field and both handshake levels on each cycle. It changes inputs only away from the clock edge and never needs `in_valid` to be held stable. Directed beats cover the negative offset extreme, a PC of zero that wraps the return address, an odd link value with both stay requests low, and a target whose bit 1 must be cleared when switching state.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
  typedef enum logic {
    HALF_HEAD = 1'b0,
    HALF_TAIL = 1'b1
  } half_e;

  localparam int unsigned HEAD_SEQ_COST  = 1;
  localparam int unsigned HEAD_NSEQ_COST = 0;
  localparam int unsigned TAIL_SEQ_COST  = 2;
  localparam int unsigned TAIL_NSEQ_COST = 1;
endpackage

// File: rtl/lbl_offset_unit.sv
module lbl_offset_unit #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 11,
  parameter int HEAD_SHIFT = 12,
  parameter int TAIL_SHIFT = 1,
  parameter int RET_BACK   = 2
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] lr,
  output logic [ADDR_W-1:0] head_lr,
  output logic [ADDR_W-1:0] tail_raw,
  output logic [ADDR_W-1:0] ret_lr
);
  localparam int HEAD_EXT = ADDR_W - OFF_W - HEAD_SHIFT;
  localparam int TAIL_EXT = ADDR_W - OFF_W - TAIL_SHIFT;

  logic [ADDR_W-1:0] head_term;
  logic [ADDR_W-1:0] tail_term;
  logic [ADDR_W-1:0] back_pc;

  // upper offset part: signed, scaled to the head position
  assign head_term = {{HEAD_EXT{offset[OFF_W-1]}}, offset, {HEAD_SHIFT{1'b0}}};
  // lower offset part: unsigned, halfword scaled
  assign tail_term = {{TAIL_EXT{1'b0}}, offset, {TAIL_SHIFT{1'b0}}};

  assign head_lr  = pc + head_term;
  assign tail_raw = lr + tail_term;
  assign back_pc  = pc - ADDR_W'(RET_BACK);
  // return address marked as compact-mode code
  assign ret_lr   = {back_pc[ADDR_W-1:1], 1'b1};
endmodule

// File: rtl/lbl_state_resolve.sv
module lbl_state_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              is_tail,
  input  logic              stay_req,
  input  logic [ADDR_W-1:0] raw,
  output logic [ADDR_W-1:0] target,
  output logic              compact
);
  logic [ADDR_W-1:0] adj;

  always_comb begin
    adj = raw;
    if (stay_req) adj[0] = 1'b1;
    if (!is_tail) begin
      target  = '0;
      compact = 1'b1;
    end else if (adj[0]) begin
      target  = {adj[ADDR_W-1:1], 1'b0};
      compact = 1'b1;
    end else begin
      target  = {adj[ADDR_W-1:2], 2'b00};
      compact = 1'b0;
    end
  end
endmodule

// File: rtl/lbl_out_stage.sv
module lbl_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          full_q;
  logic [DW-1:0] data_q;
  logic          load;

  assign in_ready  = !full_q || out_ready;
  assign load      = in_valid && in_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  // R8: a stalled result is neither dropped nor altered
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/lbl_combiner.sv
module lbl_combiner #(
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 11,
  parameter int HEAD_SHIFT = 12,
  parameter int TAIL_SHIFT = 1,
  parameter int RET_BACK   = 2,
  parameter int COST_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_core,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_tail,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic              in_sel,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_lr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_lr,
  output logic              out_branch,
  output logic [ADDR_W-1:0] out_target,
  output logic              out_compact,
  output logic [COST_W-1:0] out_seq_cyc,
  output logic [COST_W-1:0] out_nseq_cyc
);
  import lbl_pkg::*;

  localparam int DW = 2 * ADDR_W + 2 + 2 * COST_W;

  half_e             half;
  logic [ADDR_W-1:0] head_lr, tail_raw, ret_lr;
  logic [ADDR_W-1:0] nx_target, nx_lr;
  logic              nx_compact;
  logic [COST_W-1:0] nx_seq, nx_nseq;
  logic [DW-1:0]     pack_in, pack_out;

  assign half = in_tail ? HALF_TAIL : HALF_HEAD;

  lbl_offset_unit #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .HEAD_SHIFT(HEAD_SHIFT),
    .TAIL_SHIFT(TAIL_SHIFT), .RET_BACK(RET_BACK)
  ) u_off (
    .offset(in_offset), .pc(in_pc), .lr(in_lr),
    .head_lr(head_lr), .tail_raw(tail_raw), .ret_lr(ret_lr)
  );

  lbl_state_resolve #(.ADDR_W(ADDR_W)) u_state (
    .is_tail(half == HALF_TAIL),
    .stay_req(legacy_core || in_sel),
    .raw(tail_raw),
    .target(nx_target),
    .compact(nx_compact)
  );

  always_comb begin
    if (half == HALF_TAIL) begin
      nx_lr   = ret_lr;
      nx_seq  = COST_W'(TAIL_SEQ_COST);
      nx_nseq = COST_W'(TAIL_NSEQ_COST);
    end else begin
      nx_lr   = head_lr;
      nx_seq  = COST_W'(HEAD_SEQ_COST);
      nx_nseq = COST_W'(HEAD_NSEQ_COST);
    end
  end

  assign pack_in = {nx_lr, (half == HALF_TAIL), nx_target, nx_compact, nx_seq, nx_nseq};

  lbl_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(pack_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pack_out)
  );

  assign {out_lr, out_branch, out_target, out_compact, out_seq_cyc, out_nseq_cyc} = pack_out;

  // R8: a waiting result blocks the input
  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R2: head results carry single sequential cost and no jump
  assert_head_cost_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_branch |-> out_seq_cyc == 2'd1 && out_nseq_cyc == 2'd0 && out_compact);
  // R7: tail results carry the jump cost
  assert_tail_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_branch |-> out_seq_cyc == 2'd2 && out_nseq_cyc == 2'd1);
  // R4: return address always marks compact code
  assert_ret_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_branch |-> out_lr[0]);
  // R5: compact targets are halfword aligned
  assert_compact_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_branch && out_compact |-> !out_target[0]);
  // R6: 32-bit targets are word aligned
  assert_word_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_branch && !out_compact |-> out_target[1:0] == 2'b00);
endmodule

// File: tb/tb_lbl_combiner.sv
`timescale 1ns/100ps
module tb_lbl_combiner;
  typedef struct packed {
    logic [31:0] lr;
    logic        br;
    logic [31:0] tgt;
    logic        cmp;
    logic [1:0]  s;
    logic [1:0]  n;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic legacy_core = 1'b0, in_valid = 1'b0, in_tail = 1'b0, in_sel = 1'b0, out_ready = 1'b0;
  logic [10:0] in_offset = '0;
  logic [31:0] in_pc = '0, in_lr = '0;
  logic in_ready, out_valid, out_branch, out_compact;
  logic [31:0] out_lr, out_target;
  logic [1:0] out_seq_cyc, out_nseq_cyc;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  exp_t expq[$];
  bit   stalled = 1'b0;
  exp_t held;

  always #2.5 clk = ~clk;

  lbl_combiner dut (
    .clk(clk), .rst_n(rst_n), .legacy_core(legacy_core),
    .in_valid(in_valid), .in_ready(in_ready), .in_tail(in_tail),
    .in_offset(in_offset), .in_sel(in_sel), .in_pc(in_pc), .in_lr(in_lr),
    .out_valid(out_valid), .out_ready(out_ready), .out_lr(out_lr),
    .out_branch(out_branch), .out_target(out_target), .out_compact(out_compact),
    .out_seq_cyc(out_seq_cyc), .out_nseq_cyc(out_nseq_cyc)
  );

  function automatic exp_t model(logic tail, logic [10:0] off, logic sel,
                                 logic [31:0] pc, logic [31:0] lr, logic leg);
    exp_t e;
    logic [31:0] raw;
    if (!tail) begin
      e.lr = pc + {{9{off[10]}}, off, 12'h000};
      e.br = 1'b0; e.tgt = '0; e.cmp = 1'b1; e.s = 2'd1; e.n = 2'd0;
    end else begin
      raw = lr + {20'h0, off, 1'b0};
      if (leg || sel) raw[0] = 1'b1;
      e.lr = (pc - 32'd2) | 32'd1;
      e.br = 1'b1; e.s = 2'd2; e.n = 2'd1;
      if (raw[0]) begin e.tgt = raw & ~32'd1; e.cmp = 1'b1; end
      else        begin e.tgt = raw & ~32'd3; e.cmp = 1'b0; end
    end
    return e;
  endfunction

  function automatic exp_t observed();
    exp_t o;
    o.lr = out_lr; o.br = out_branch; o.tgt = out_target; o.cmp = out_compact;
    o.s = out_seq_cyc; o.n = out_nseq_cyc;
    return o;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(exp_t e);
    exp_t o = observed();
    if (!e.br) begin
      chk("R1 head link", {32'h0, o.lr}, {32'h0, e.lr});
      chk("R2 head flags/cost", {58'h0, o.br, o.cmp, o.s, o.n}, {58'h0, e.br, e.cmp, e.s, e.n});
      chk("R2 head target", {32'h0, o.tgt}, {32'h0, e.tgt});
    end else begin
      chk("R4 return link", {32'h0, o.lr}, {32'h0, e.lr});
      chk("R7 tail flag/cost", {59'h0, o.br, o.s, o.n}, {59'h0, e.br, e.s, e.n});
      if (e.cmp) chk("R3 R5 compact target", {31'h0, o.cmp, o.tgt}, {31'h0, e.cmp, e.tgt});
      else       chk("R3 R6 switch target", {31'h0, o.cmp, o.tgt}, {31'h0, e.cmp, e.tgt});
    end
  endtask

  // inputs already set for the coming edge; returns 1 if the beat is taken
  task automatic cycle(output bit taken);
    #1;
    if (stalled) begin
      chk("R8 hold valid", {63'h0, out_valid}, 64'h1);
      if (out_valid) chk("R8 hold data", {25'h0, observed()}, {25'h0, held});
    end
    chk("R8 ready rule", {63'h0, in_ready}, {63'h0, (!out_valid || out_ready)});
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk("R8 extra result", 64'h1, 64'h0);
      else compare(expq.pop_front());
    end
    stalled = out_valid && !out_ready;
    held = observed();
    taken = in_valid && in_ready;
    if (taken) expq.push_back(model(in_tail, in_offset, in_sel, in_pc, in_lr, legacy_core));
    @(negedge clk);
  endtask

  task automatic send(logic tail, logic [10:0] off, logic sel,
                      logic [31:0] pc, logic [31:0] lr, logic leg);
    bit t;
    in_valid = 1'b1; in_tail = tail; in_offset = off; in_sel = sel;
    in_pc = pc; in_lr = lr; legacy_core = leg; out_ready = 1'b1;
    t = 1'b0;
    while (!t) cycle(t);
    in_valid = 1'b0;
  endtask

  initial begin
    bit t;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {63'h0, out_valid}, 64'h0);
    chk("R9 reset ready", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 post reset valid", {63'h0, out_valid}, 64'h0);

    // directed corners
    send(1'b0, 11'h400, 1'b0, 32'h0000_1000, 32'h0, 1'b0); // R1 most negative offset
    send(1'b0, 11'h3FF, 1'b0, 32'hFFFF_F000, 32'h0, 1'b0); // R1 wraps
    send(1'b1, 11'h7FF, 1'b1, 32'h0000_0000, 32'h0000_2000, 1'b0); // R4 pc wraps, R5 sel
    send(1'b1, 11'h001, 1'b0, 32'h0000_0100, 32'h0000_2000, 1'b1); // R5 legacy
    send(1'b1, 11'h010, 1'b0, 32'h0000_0100, 32'h0000_2001, 1'b0); // R5 odd link
    send(1'b1, 11'h001, 1'b0, 32'h0000_0100, 32'h0000_2000, 1'b0); // R6 bit1 cleared
    send(1'b1, 11'h000, 1'b0, 32'h0000_0100, 32'h0000_3004, 1'b0); // R6 aligned
    repeat (2) begin in_valid = 1'b0; cycle(t); end

    // random traffic with back-pressure
    for (int i = 0; i < 3000; i++) begin
      in_valid    = ($urandom_range(0, 9) < 7);
      in_tail     = $urandom_range(0, 1);
      in_offset   = 11'($urandom);
      in_sel      = $urandom_range(0, 1);
      legacy_core = ($urandom_range(0, 3) == 0);
      in_pc       = $urandom & ~32'd1;
      in_lr       = $urandom;
      out_ready   = ($urandom_range(0, 9) < 7);
      cycle(t);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) cycle(t);
    chk("R8 all results delivered", 64'(expq.size()), 64'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule